// File: doc/BRIEF.md
# SD Card Clock Divider

This block turns a fast base clock into the much slower rate at which an SD card is clocked. The ratio is the product of two settings. A prescaler setting is one-hot: bit i set divides by 2^(i+1), and the all-zero code skips the prescaler. A divisor setting n divides by n+1. The block does not make a second clock net. It emits a one-cycle strobe, `card_tick`, once per output period, in the base clock domain, and the pad logic or the card interface uses that strobe as its clock enable. The strobe resumes only at a period boundary, so the card never sees a runt pulse.

The block also keeps a copy of the settings it is running with. When either input setting differs from that copy, the copy takes the new value and a `clk_stable` flag drops. The flag comes back after one full output period at the new ratio. Software must hold `card_clk_en` low while it changes the settings and may raise it again once `clk_stable` is set. Strobes appear only while the enable is high and the flag is set.

The control is a three-state machine:
- ST_SETTLE: the flag is low and the period counter runs once through a full period at the new ratio. A settings change while here restarts the count. When the count ends, the machine moves to ST_READY.
- ST_READY: the flag is high and the output is quiet. The machine moves to ST_RUN when the enable is high, and to ST_SETTLE on a settings change.
- ST_RUN: the flag is high and one strobe is sent per period. At the end of a period with the enable low, the machine moves to ST_READY. A settings change moves it to ST_SETTLE at once.

After reset the block is in ST_SETTLE, with its settings copy at prescaler 80h and divisor 0.

Top module: `sdclk_divider`

## Requirements
- R1: While running, `card_tick` strobes once every P×D base cycles, where P is the prescaler factor and D the divisor factor. The largest ratio, prescaler 80h with divisor Fh, gives 4096.
- R2: A prescaler setting with only bit i set gives P = 2^(i+1). For example, 01h gives 2, 08h gives 16 and 80h gives 256.
- R3: A prescaler setting of 00h gives P = 1. With divisor 0, this strobes on every base cycle.
- R4: A divisor setting n gives D = n+1. For example, prescaler 08h with divisor Eh gives a ratio of 240, which is 400 kHz from 96 MHz.
- R5: While reset is asserted, `clk_stable` and `card_tick` are low. The settings copy resets to prescaler 80h and divisor 0. With the inputs held at those values, `clk_stable` rises after the 256th base clock edge following reset release.
- R6: If more than one prescaler bit is set, only the highest set bit sets P. For example, 0Ah acts as 08h.
- R7: A base clock edge that sees the inputs differ from the settings copy clears `clk_stable` and stops strobes. `clk_stable` is set again after N further edges, where N is the new ratio.
- R8: `card_tick` never strobes while `clk_stable` is low. This holds even if `card_clk_en` is already high during settling.
- R9: When the enable rises while the block is settled, the first strobe comes N+1 edges later. When the enable falls, the period in progress still ends with its strobe, and then no further strobes follow.
- R10: `card_tick` is registered. Except at ratio 1, it is high for exactly one base cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| base_clk | input | 1 | Base clock that is divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_sel | input | 8 | One-hot prescaler setting; 00h skips the prescaler |
| div_sel | input | 4 | Divisor setting n, divides by n+1 |
| card_clk_en | input | 1 | Request for the card clock to run |
| card_tick | output | 1 | One-cycle strobe per output period |
| clk_stable | output | 1 | Set when the ratio has settled and the enable may be raised |

## Verification
The bench pushes the ratio to both ends. It uses the bypass with divisor 0, where a design that inserts even one idle cycle halves the rate, and the 4096 maximum, where a counter one bit too narrow wraps early. It sets several prescaler bits at once, to catch a design that ORs or sums the bits instead of taking the highest one. It holds the enable high across a settings change, to expose a design that strobes before `clk_stable` returns. It drops the enable mid-period: a design that gates at once cuts the last period short, and a design that ignores the enable keeps strobing.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    // Control states of the divider
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,   // new ratio in use, waiting one full period
        ST_READY  = 2'd1,   // ratio settled, output held quiet
        ST_RUN    = 2'd2    // strobes issued once per period
    } sdclk_state_e;

endpackage

// File: rtl/sdclk_ratio.sv
// Converts the settings copy into the last count of one output period (ratio - 1).
module sdclk_ratio #(
    parameter int PRESC_W = 8,
    parameter int DIV_W   = 4,
    parameter int CNT_W   = DIV_W + PRESC_W + 1
) (
    input  logic [PRESC_W-1:0] presc,
    input  logic [DIV_W-1:0]   divf,
    output logic [CNT_W-1:0]   last
);
    localparam int SH_W = $clog2(PRESC_W + 2);

    logic [SH_W-1:0]  shift_amt;
    logic [CNT_W-1:0] div_factor;

    // The highest set bit wins: later loop passes overwrite earlier ones
    always_comb begin
        shift_amt = '0;
        for (int i = 0; i < PRESC_W; i++) begin
            if (presc[i]) begin
                shift_amt = SH_W'(i + 1);
            end
        end
    end

    assign div_factor = CNT_W'(divf) + CNT_W'(1);
    assign last       = (div_factor << shift_amt) - CNT_W'(1);

endmodule

// File: rtl/sdclk_field_watch.sv
// Holds the settings in use and flags any difference from the inputs.
module sdclk_field_watch #(
    parameter int                 PRESC_W   = 8,
    parameter int                 DIV_W     = 4,
    parameter logic [PRESC_W-1:0] RST_PRESC = {1'b1, {(PRESC_W-1){1'b0}}},
    parameter logic [DIV_W-1:0]   RST_DIV   = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc_in,
    input  logic [DIV_W-1:0]   div_in,
    output logic [PRESC_W-1:0] presc_act,
    output logic [DIV_W-1:0]   div_act,
    output logic               changed
);
    assign changed = (presc_in != presc_act) || (div_in != div_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_act <= RST_PRESC;
            div_act   <= RST_DIV;
        end else if (changed) begin
            presc_act <= presc_in;
            div_act   <= div_in;
        end
    end

endmodule

// File: rtl/sdclk_phase_cnt.sv
// Counts base cycles within one output period.
module sdclk_phase_cnt #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] last,
    output logic             at_end
);
    logic [CNT_W-1:0] cnt_q;

    assign at_end = (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter int PRESC_W = 8,
    parameter int DIV_W   = 4
) (
    input  logic               base_clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc_sel,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic               card_clk_en,
    output logic               card_tick,
    output logic               clk_stable
);
    localparam int CNT_W = DIV_W + PRESC_W + 1;

    sdclk_state_e       state_q, state_d;
    logic [PRESC_W-1:0] presc_act;
    logic [DIV_W-1:0]   div_act;
    logic [CNT_W-1:0]   period_last;
    logic               fields_changed;
    logic               at_end;
    logic               cnt_clr;

    sdclk_field_watch #(
        .PRESC_W  (PRESC_W),
        .DIV_W    (DIV_W),
        .RST_PRESC({1'b1, {(PRESC_W-1){1'b0}}}),
        .RST_DIV  ('0)
    ) u_watch (
        .clk      (base_clk),
        .rst_n    (rst_n),
        .presc_in (presc_sel),
        .div_in   (div_sel),
        .presc_act(presc_act),
        .div_act  (div_act),
        .changed  (fields_changed)
    );

    sdclk_ratio #(
        .PRESC_W(PRESC_W),
        .DIV_W  (DIV_W),
        .CNT_W  (CNT_W)
    ) u_ratio (
        .presc(presc_act),
        .divf (div_act),
        .last (period_last)
    );

    // The counter restarts on a change, at every period end and while idle
    assign cnt_clr = fields_changed || at_end || (state_q == ST_READY);

    sdclk_phase_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk   (base_clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .last  (period_last),
        .at_end(at_end)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (fields_changed) begin
            state_d = ST_SETTLE;
        end else begin
            unique case (state_q)
                ST_SETTLE: if (at_end)                     state_d = ST_READY;
                ST_READY:  if (card_clk_en)                state_d = ST_RUN;
                ST_RUN:    if (at_end && !card_clk_en)     state_d = ST_READY;
                default:                                   state_d = ST_SETTLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge base_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: strobe is registered, stable decodes the state
    always_ff @(posedge base_clk or negedge rst_n) begin
        if (!rst_n) begin
            card_tick <= 1'b0;
        end else begin
            card_tick <= !fields_changed && (state_q == ST_RUN) && at_end;
        end
    end

    assign clk_stable = (state_q != ST_SETTLE);

endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk #(
    parameter int PRESC_W = 8,
    parameter int DIV_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PRESC_W-1:0] presc_sel,
    input logic [DIV_W-1:0]   div_sel,
    input logic               card_tick,
    input logic               clk_stable
);
    // R8: a strobe is only seen while the ratio is settled
    a_r8_tick_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        card_tick |-> clk_stable);

    // R8: no strobe follows a cycle in which the flag was low
    a_r8_quiet_when_unstable: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_stable |=> !card_tick);

    // R7: a settings change clears the flag on the following edge
    a_r7_change_drops_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((presc_sel != $past(presc_sel)) || (div_sel != $past(div_sel))) |=> !clk_stable);

    // R7: the flag only falls because the settings changed
    a_r7_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_stable) |-> (($past(presc_sel) != $past(presc_sel, 2)) ||
                               ($past(div_sel) != $past(div_sel, 2))));
endmodule

bind sdclk_divider sdclk_divider_chk #(
    .PRESC_W(PRESC_W),
    .DIV_W  (DIV_W)
) u_chk (
    .clk       (base_clk),
    .rst_n     (rst_n),
    .presc_sel (presc_sel),
    .div_sel   (div_sel),
    .card_tick (card_tick),
    .clk_stable(clk_stable)
);

// File: tb/sim_sdclk_divider.sv
module sim_sdclk_divider;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] presc;
    logic [3:0] divs;
    logic       en;
    logic       card_tick;
    logic       clk_stable;

    int n_chk = 0;
    int n_err = 0;

    // Behavioural model state
    int m_mode;   // 0 settling, 1 settled idle, 2 running
    int m_left;
    int m_phase;
    int m_ratio;
    int m_p;
    int m_d;
    bit m_tick;

    always #2 clk = ~clk;   // 250 MHz

    sdclk_divider u0 (
        .base_clk   (clk),
        .rst_n      (rst_n),
        .presc_sel  (presc),
        .div_sel    (divs),
        .card_clk_en(en),
        .card_tick  (card_tick),
        .clk_stable (clk_stable)
    );

    function automatic int ratio_of(int p, int d);
        int s = 0;
        for (int i = 0; i < 8; i++) if (p[i]) s = i + 1;
        return (d + 1) * (1 << s);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_p = 8'h80; m_d = 0; m_ratio = 256;
            m_mode = 0; m_left = 256; m_phase = 0; m_tick = 0;
        end else if (int'(presc) != m_p || int'(divs) != m_d) begin
            m_p = int'(presc); m_d = int'(divs); m_ratio = ratio_of(m_p, m_d);
            m_mode = 0; m_left = m_ratio; m_phase = 0; m_tick = 0;
        end else begin
            m_tick = 0;
            case (m_mode)
                0: begin m_left--; if (m_left == 0) m_mode = 1; end
                1: if (en) begin m_mode = 2; m_phase = 0; end
                default: begin
                    m_phase++;
                    if (m_phase == m_ratio) begin
                        m_tick = 1; m_phase = 0;
                        if (!en) m_mode = 1;
                    end
                end
            endcase
        end
    end

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            chk(card_tick === m_tick, "R10 per-cycle strobe", int'(card_tick), int'(m_tick));
            chk(clk_stable === (m_mode != 0), "R7 per-cycle stable", int'(clk_stable), int'(m_mode != 0));
        end
    end

    task automatic count_settle(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!clk_stable && n < 10000);
    endtask

    task automatic first_tick(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!card_tick && n < 10000);
    endtask

    task automatic tick_gap(output int n);
        int w = 0;
        while (!card_tick && w < 10000) begin @(negedge clk); w++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!card_tick && n < 10000);
    endtask

    task automatic reconfig(int p, int d, int prev, string tag);
        int n;
        int exp = ratio_of(p, d);
        en = 1'b0;
        repeat (prev + 2) @(negedge clk);
        presc = 8'(p); divs = 4'(d);
        count_settle(n);
        chk(n == exp + 1, {tag, " settle after change (R7)"}, n, exp + 1);
        en = 1'b1;
        tick_gap(n);
        chk(n == exp, {tag, " strobe period"}, n, exp);
    endtask

    initial begin
        int n;
        int t;
        rst_n = 1'b0; presc = 8'h80; divs = 4'h0; en = 1'b0;
        repeat (3) @(negedge clk);
        chk(clk_stable == 1'b0, "R5 stable low in reset", int'(clk_stable), 0);
        chk(card_tick == 1'b0, "R5 strobe low in reset", int'(card_tick), 0);
        rst_n = 1'b1;
        count_settle(n);
        chk(n == 256, "R5 settle from reset", n, 256);
        en = 1'b1;
        first_tick(n);
        chk(n == 257, "R9 first strobe latency", n, 257);
        tick_gap(n);
        chk(n == 256, "R2 reset ratio 256", n, 256);

        reconfig(8'h01, 1, 256, "R2 R4 ratio 4");
        @(negedge clk);
        chk(card_tick == 1'b0, "R10 single-cycle pulse", int'(card_tick), 0);

        reconfig(8'h00, 0, 4, "R3 bypass ratio 1");
        t = 0;
        repeat (8) begin @(negedge clk); if (card_tick) t++; end
        chk(t == 8, "R3 strobe every cycle", t, 8);

        reconfig(8'h08, 14, 1, "R4 ratio 240");
        reconfig(8'h0A, 2, 240, "R6 highest bit ratio 48");

        // R8: enable already high while settling
        @(negedge clk);
        presc = 8'h02; divs = 4'h3;   // ratio 16
        n = 0; t = 0;
        do begin @(negedge clk); n++; if (card_tick) t++; end while (!clk_stable && n < 10000);
        chk(t == 0, "R8 no strobe while settling", t, 0);
        chk(n == 17, "R7 settle ratio 16", n, 17);

        // R9: enable falls mid-period
        tick_gap(n);
        repeat (5) @(negedge clk);
        en = 1'b0;
        t = 0;
        repeat (40) begin @(negedge clk); if (card_tick) t++; end
        chk(t == 1, "R9 period completes then stops", t, 1);
        chk(clk_stable == 1'b1, "R9 still settled after disable", int'(clk_stable), 1);

        // R7: change while running
        en = 1'b1;
        tick_gap(n);
        repeat (3) @(negedge clk);
        presc = 8'h01; divs = 4'h0;
        @(negedge clk);
        chk(clk_stable == 1'b0, "R7 flag drops after change", int'(clk_stable), 0);

        reconfig(8'h80, 15, 4, "R1 max ratio 4096");
        en = 1'b0;
        repeat (4100) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule